// File: doc/BRIEF.md
# Shared-Timebase Compare/Capture Array

This block holds one 16-bit up-counter and a row of identical channels that watch it. The counter advances by one on each clock where the run bit is set and the `tick` qualifier is high. Each channel owns a 16-bit compare/capture value, split into a low and a high byte, and a mode byte. The mode selects what the channel does with the shared count. A capture channel records the count on a rising or falling edge of its pin. A software-timer channel raises an event on a match. A high-speed-output channel also flips its pin on a match. A PWM channel drives an 8-bit duty comparison, and a new duty value is loaded only when a period ends. The last channel can also act as a watchdog that pulses a reset output on a match.

Software reaches the block through a simple byte-wide write strobe and a combinational read port. One interrupt line collects the counter overflow flag and the per-channel event flags, each gated by its own enable.

Top module: `tick_compare_array`

## Requirements
- R1: Address map: 0 = control (bit 6 run, bit 7 overflow flag, bit n = event flag of channel n), 1 = global mode (bit 0 overflow interrupt enable, bit 1 watchdog enable), 2 = count low byte, 3 = count high byte, 4+3n = channel n mode, 5+3n = channel n compare low, 6+3n = channel n compare high. Channel mode bits are: 0 interrupt enable, 1 PWM, 2 toggle, 3 match enable, 4 falling capture, 5 rising capture. The counter advances by one on each clock with run=1 and tick=1, holds otherwise, and bus writes to its bytes load it.
- R2: When the count steps from FFFFh to 0000h, the overflow flag is set. irq is high while the flag and the overflow interrupt enable are both set.
- R3: A control write clears each flag whose written bit is 0 and leaves a flag unchanged where the bit is 1; writing 1 never sets a flag.
- R4: A write to a channel's compare low byte clears its match enable; a write to its compare high byte sets it.
- R5: Software timer (match enable only): in a counting clock where the count equals the 16-bit compare value, the channel's event flag is set at that edge. irq follows the flag when the channel's interrupt enable is set, and stays low otherwise.
- R6: High-speed output (match enable + toggle): the same match inverts the channel's cex_out bit and sets its event flag.
- R7: PWM (match enable + PWM): cex_out is 0 while count low byte < compare low byte and 1 otherwise. When the count low byte wraps from FFh, compare high is copied into compare low, so a new duty set in the high byte appears only at a period boundary. PWM sets no event flag.
- R8: Capture: with rising (bit 5) or falling (bit 4) capture selected, that edge on cex_in copies both count bytes into the compare registers and sets the event flag. The other edge does nothing.
- R9: The last channel, with the watchdog enable set and match enable without PWM, drives wdt_rst high for exactly one clock after a match and sets no flag. Rewriting the compare value before the count reaches it avoids the pulse.
- R10: After reset, all registers, flags, cex_out, irq and wdt_rst are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count qualifier |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cex_in | input | 5 | Channel capture inputs |
| cex_out | output | 5 | Channel outputs (toggle or PWM) |
| irq | output | 1 | Combined interrupt |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
A wrong count shows up in the next read of the count bytes, and in every channel that compares against it. A match slipped by even one value moves the flag or the toggle by one clock, and the bench samples each such edge in the exact cycle it is due. A stale PWM reload shows as a wrong compare-low read right after the low-byte wrap. A wrongly set watchdog pulse is counted on every falling clock edge, so a spurious or doubled pulse is caught as soon as the window closes.

// File: rtl/tca_pkg.sv
package tca_pkg;
   // channel mode bit positions
   localparam int MB_IE   = 0;
   localparam int MB_PWM  = 1;
   localparam int MB_TOG  = 2;
   localparam int MB_MAT  = 3;
   localparam int MB_CAPN = 4;
   localparam int MB_CAPP = 5;
   localparam int MODE_W  = 6;
   // register address map
   localparam int A_CTRL      = 0;
   localparam int A_GMODE     = 1;
   localparam int A_CNTL      = 2;
   localparam int A_CNTH      = 3;
   localparam int A_CHAN0     = 4;
   localparam int CHAN_STRIDE = 3;
   // control bit positions
   localparam int CB_RUN = 6;
   localparam int CB_OVF = 7;
endpackage

// File: rtl/tca_timebase.sv
module tca_timebase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             inc,
   output logic             wrap,
   output logic             lo_wrap
);
   localparam int HALF = CNT_W / 2;

   if (CNT_W != 16) begin : g_bad_width
      $error("tca_timebase: CNT_W must be 16");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign inc     = run && tick;
   assign wrap    = inc && (cnt_q == {CNT_W{1'b1}});
   assign lo_wrap = inc && (cnt_q[HALF-1:0] == {HALF{1'b1}});
   assign cnt     = cnt_q;

   always_comb begin
      cnt_d = inc ? cnt_q + 1'b1 : cnt_q;
      if (wr_lo) cnt_d[HALF-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:HALF] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // R1: one step per counting clock
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !wr_lo && !wr_hi |=> cnt_q == $past(cnt_q) + 1'b1);
   // R1: no step without run and tick
   a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !wr_lo && !wr_hi |=> $stable(cnt_q));
endmodule

// File: rtl/tca_channel.sv
module tca_channel
   import tca_pkg::*;
#(
   parameter bit IS_WDOG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cnt,
   input  logic              inc,
   input  logic              lo_wrap,
   input  logic              wr_mode,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [7:0]        wdata,
   input  logic              flag_clr,
   input  logic              wdog_en,
   input  logic              cex_in,
   output logic [MODE_W-1:0] mode,
   output logic [7:0]        cmp_lo,
   output logic [7:0]        cmp_hi,
   output logic              flag,
   output logic              cex_out,
   output logic              wd_hit
);
   logic [MODE_W-1:0] mode_q;
   logic [7:0]        lo_q, hi_q;
   logic              flag_q, out_q, pin_q;
   logic              pwm_on, wd_mode, matched, cap_evt, toggle_evt, flag_set;

   assign pwm_on     = mode_q[MB_MAT] && mode_q[MB_PWM];
   assign wd_mode    = IS_WDOG && wdog_en && mode_q[MB_MAT] && !mode_q[MB_PWM];
   assign matched    = inc && mode_q[MB_MAT] && !mode_q[MB_PWM] && (cnt == {hi_q, lo_q});
   assign cap_evt    = (mode_q[MB_CAPP] && cex_in && !pin_q) ||
                       (mode_q[MB_CAPN] && !cex_in && pin_q);
   assign toggle_evt = matched && mode_q[MB_TOG] && !wd_mode;
   assign flag_set   = cap_evt || (matched && !wd_mode);
   assign wd_hit     = matched && wd_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         flag_q <= 1'b0;
         out_q  <= 1'b0;
         pin_q  <= 1'b0;
      end else begin
         pin_q <= cex_in;
         if (wr_mode)    mode_q <= wdata[MODE_W-1:0];
         else if (wr_lo) mode_q[MB_MAT] <= 1'b0;
         else if (wr_hi) mode_q[MB_MAT] <= 1'b1;
         if (wr_lo)                  lo_q <= wdata;
         else if (cap_evt)           lo_q <= cnt[7:0];
         else if (pwm_on && lo_wrap) lo_q <= hi_q;
         if (wr_hi)        hi_q <= wdata;
         else if (cap_evt) hi_q <= cnt[15:8];
         if (flag_set)      flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
         if (toggle_evt) out_q <= !out_q;
      end
   end

   assign mode    = mode_q;
   assign cmp_lo  = lo_q;
   assign cmp_hi  = hi_q;
   assign flag    = flag_q;
   assign cex_out = pwm_on ? (cnt[7:0] >= lo_q) : out_q;

   // R4: low compare write drops the match enable
   a_r4_lo_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> !mode_q[MB_MAT]);
   // R4: high compare write raises it
   a_r4_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi && !wr_lo && !wr_mode |=> mode_q[MB_MAT]);
   // R6: toggle event flips the pin
   a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      toggle_evt |=> out_q != $past(out_q));
   // R7: duty reload at the period boundary
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_on && lo_wrap && !wr_lo && !cap_evt |=> lo_q == $past(hi_q));
   // R8: capture latches the count and flags
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt && !wr_lo && !wr_hi |=> (lo_q == $past(cnt[7:0])) && (hi_q == $past(cnt[15:8])) && flag_q);
endmodule

// File: rtl/tick_compare_array.sv
module tick_compare_array
   import tca_pkg::*;
#(
   parameter int NMOD   = 5,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [NMOD-1:0]   cex_in,
   output logic [NMOD-1:0]   cex_out,
   output logic              irq,
   output logic              wdt_rst
);
   localparam int CNT_W  = 16;
   localparam int N_REGS = A_CHAN0 + CHAN_STRIDE * NMOD;

   if (NMOD < 1 || NMOD > CB_RUN) begin : g_bad_nmod
      $error("tick_compare_array: NMOD out of range");
   end
   if ((1 << ADDR_W) < N_REGS) begin : g_bad_addr
      $error("tick_compare_array: ADDR_W too small");
   end

   logic [CNT_W-1:0] cnt;
   logic             inc, wrap, lo_wrap;
   logic             run_q, ovf_q, ovf_ie_q, wdog_en_q, wdt_q;
   logic             wr_ctrl, wr_gmode, wr_cntl, wr_cnth;
   logic [NMOD-1:0]  flag, hit, ie_vec;
   logic [MODE_W-1:0] mode_a [NMOD];
   logic [7:0]        lo_a   [NMOD];
   logic [7:0]        hi_a   [NMOD];

   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign wr_gmode = bus_wr && (bus_addr == ADDR_W'(A_GMODE));
   assign wr_cntl  = bus_wr && (bus_addr == ADDR_W'(A_CNTL));
   assign wr_cnth  = bus_wr && (bus_addr == ADDR_W'(A_CNTH));

   tca_timebase #(.CNT_W(CNT_W)) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .tick    (tick),
      .wr_lo   (wr_cntl),
      .wr_hi   (wr_cnth),
      .wdata   (bus_wdata),
      .cnt     (cnt),
      .inc     (inc),
      .wrap    (wrap),
      .lo_wrap (lo_wrap)
   );

   for (genvar i = 0; i < NMOD; i++) begin : g_chan
      localparam int BASE = A_CHAN0 + CHAN_STRIDE * i;
      logic wr_m, wr_l, wr_h;
      assign wr_m = bus_wr && (bus_addr == ADDR_W'(BASE));
      assign wr_l = bus_wr && (bus_addr == ADDR_W'(BASE + 1));
      assign wr_h = bus_wr && (bus_addr == ADDR_W'(BASE + 2));

      tca_channel #(.IS_WDOG(i == NMOD - 1)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt      (cnt),
         .inc      (inc),
         .lo_wrap  (lo_wrap),
         .wr_mode  (wr_m),
         .wr_lo    (wr_l),
         .wr_hi    (wr_h),
         .wdata    (bus_wdata),
         .flag_clr (wr_ctrl && !bus_wdata[i]),
         .wdog_en  (wdog_en_q),
         .cex_in   (cex_in[i]),
         .mode     (mode_a[i]),
         .cmp_lo   (lo_a[i]),
         .cmp_hi   (hi_a[i]),
         .flag     (flag[i]),
         .cex_out  (cex_out[i]),
         .wd_hit   (hit[i])
      );
      assign ie_vec[i] = mode_a[i][MB_IE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         ovf_q     <= 1'b0;
         ovf_ie_q  <= 1'b0;
         wdog_en_q <= 1'b0;
         wdt_q     <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[CB_RUN];
            ovf_q <= wrap || (ovf_q && bus_wdata[CB_OVF]);
         end else if (wrap) begin
            ovf_q <= 1'b1;
         end
         if (wr_gmode) begin
            ovf_ie_q  <= bus_wdata[0];
            wdog_en_q <= bus_wdata[1];
         end
         wdt_q <= |hit;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_CTRL)) begin
         bus_rdata[CB_OVF] = ovf_q;
         bus_rdata[CB_RUN] = run_q;
         for (int k = 0; k < NMOD; k++) bus_rdata[k] = flag[k];
      end else if (bus_addr == ADDR_W'(A_GMODE)) begin
         bus_rdata[1:0] = {wdog_en_q, ovf_ie_q};
      end else if (bus_addr == ADDR_W'(A_CNTL)) begin
         bus_rdata = cnt[7:0];
      end else if (bus_addr == ADDR_W'(A_CNTH)) begin
         bus_rdata = cnt[15:8];
      end
      for (int k = 0; k < NMOD; k++) begin
         if (bus_addr == ADDR_W'(A_CHAN0 + CHAN_STRIDE * k))     bus_rdata = {{(8-MODE_W){1'b0}}, mode_a[k]};
         if (bus_addr == ADDR_W'(A_CHAN0 + CHAN_STRIDE * k + 1)) bus_rdata = lo_a[k];
         if (bus_addr == ADDR_W'(A_CHAN0 + CHAN_STRIDE * k + 2)) bus_rdata = hi_a[k];
      end
   end

   assign irq     = (ovf_q && ovf_ie_q) || |(flag & ie_vec);
   assign wdt_rst = wdt_q;

   // R2: counter wrap raises the overflow flag
   a_r2_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_q);
   // R9: a reset pulse only with the watchdog enabled
   a_r9_wdt_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_q |-> $past(wdog_en_q));
   // R9: the watchdog channel never raises its flag
   a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      hit[NMOD-1] |=> flag[NMOD-1] == $past(flag[NMOD-1]) || $past(wr_ctrl));
endmodule

// File: tb/tick_compare_array_bench.sv
module tick_compare_array_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [4:0] cex_in = '0;
   logic [4:0] cex_out;
   logic       irq, wdt_rst;

   int checks = 0;
   int fails  = 0;
   int wdt_seen = 0;

   localparam logic [4:0] A_CTRL = 5'd0, A_GMODE = 5'd1, A_CNTL = 5'd2, A_CNTH = 5'd3;

   tick_compare_array u_tick_compare_array (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cex_in(cex_in),
      .cex_out(cex_out), .irq(irq), .wdt_rst(wdt_rst)
   );

   always #10 clk = ~clk;

   always @(negedge clk) if (wdt_rst) wdt_seen++;

   function automatic logic [4:0] chan(int n, int k);
      return 5'(4 + 3 * n + k);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(string req, logic [4:0] a, logic [7:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic run_ticks(int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic summary_and_end();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   task automatic t_reset();   // R10
      rd_check("R10 ctrl", A_CTRL, 8'h00);
      rd_check("R10 count", A_CNTL, 8'h00);
      rd_check("R10 chan4 mode", chan(4, 0), 8'h00);
      check("R10 outputs", {cex_out, irq, wdt_rst}, 0);
   endtask

   task automatic t_count();   // R1
      wr(A_CNTH, 8'h00); wr(A_CNTL, 8'h10); wr(A_CTRL, 8'h40);
      run_ticks(7);
      rd_check("R1 counts ticks", A_CNTL, 8'h17);
      repeat (3) @(negedge clk);
      rd_check("R1 holds without tick", A_CNTL, 8'h17);
      wr(A_CTRL, 8'h00);
      run_ticks(4);
      rd_check("R1 holds without run", A_CNTL, 8'h17);
      wr(A_CTRL, 8'h40);
   endtask

   task automatic t_overflow(); // R2, R3
      wr(A_CNTH, 8'hFF); wr(A_CNTL, 8'hFE);
      run_ticks(1);
      rd_check("R2 no flag before wrap", A_CTRL, 8'h40);
      run_ticks(1);
      rd_check("R2 flag at wrap", A_CTRL, 8'hC0);
      rd_check("R2 count wrapped", A_CNTH, 8'h00);
      check("R2 irq gated off", irq, 0);
      wr(A_GMODE, 8'h01);
      check("R2 irq enabled", irq, 1);
      wr(A_CTRL, 8'h40);
      rd_check("R3 flag cleared", A_CTRL, 8'h40);
      check("R3 irq after clear", irq, 0);
      wr(A_CTRL, 8'hC0);
      rd_check("R3 write one does not set", A_CTRL, 8'h40);
   endtask

   task automatic t_enable();  // R4
      wr(chan(0, 0), 8'h08);
      rd_check("R4 mode written", chan(0, 0), 8'h08);
      wr(chan(0, 1), 8'h33);
      rd_check("R4 low write clears", chan(0, 0), 8'h00);
      wr(chan(0, 2), 8'h01);
      rd_check("R4 high write sets", chan(0, 0), 8'h08);
   endtask

   task automatic t_timer();   // R5
      wr(chan(0, 0), 8'h01); wr(chan(0, 1), 8'h05); wr(chan(0, 2), 8'h01);
      rd_check("R5 mode after compare load", chan(0, 0), 8'h09);
      wr(A_CNTH, 8'h01); wr(A_CNTL, 8'h00);
      run_ticks(5);
      rd_check("R5 no flag before match", A_CTRL, 8'h40);
      run_ticks(1);
      rd_check("R5 flag on match", A_CTRL, 8'h41);
      check("R5 irq on match", irq, 1);
      wr(chan(0, 0), 8'h00); wr(A_CTRL, 8'h40);
   endtask

   task automatic t_hso();     // R6
      wr(chan(1, 0), 8'h04); wr(chan(1, 1), 8'h20); wr(chan(1, 2), 8'h00);
      wr(A_CNTH, 8'h00); wr(A_CNTL, 8'h10);
      run_ticks(16);
      check("R6 pin before match", cex_out[1], 0);
      run_ticks(1);
      check("R6 pin toggled", cex_out[1], 1);
      rd_check("R6 flag set", A_CTRL, 8'h42);
      check("R5 irq needs enable", irq, 0);
      wr(chan(1, 0), 8'h00); wr(A_CTRL, 8'h40);
   endtask

   task automatic t_pwm();     // R7
      wr(chan(2, 0), 8'h02); wr(chan(2, 1), 8'h40); wr(chan(2, 2), 8'h80);
      wr(A_CNTH, 8'h00); wr(A_CNTL, 8'h3F);
      #1 check("R7 low below duty", cex_out[2], 0);
      @(negedge clk);
      wr(A_CNTL, 8'h40);
      #1 check("R7 equal gives high", cex_out[2], 1);
      @(negedge clk);
      wr(A_CNTL, 8'hFE);
      run_ticks(2);
      rd_check("R7 reload at wrap", chan(2, 1), 8'h80);
      check("R7 low after wrap", cex_out[2], 0);
      wr(A_CNTL, 8'h7F);
      #1 check("R7 below new duty", cex_out[2], 0);
      @(negedge clk);
      wr(chan(2, 2), 8'hC0);
      rd_check("R7 duty deferred", chan(2, 1), 8'h80);
      rd_check("R7 no flag", A_CTRL, 8'h40);
      wr(chan(2, 0), 8'h00);
   endtask

   task automatic t_capture(); // R8
      wr(chan(3, 0), 8'h21);
      wr(A_CNTH, 8'h12); wr(A_CNTL, 8'h34);
      cex_in[3] = 1'b1;
      @(negedge clk);
      rd_check("R8 rising low", chan(3, 1), 8'h34);
      rd_check("R8 rising high", chan(3, 2), 8'h12);
      rd_check("R8 flag", A_CTRL, 8'h48);
      check("R8 irq", irq, 1);
      wr(A_CTRL, 8'h40);
      wr(A_CNTH, 8'h56); wr(A_CNTL, 8'h78);
      cex_in[3] = 1'b0;
      @(negedge clk);
      rd_check("R8 falling ignored", chan(3, 1), 8'h34);
      rd_check("R8 no flag on ignored edge", A_CTRL, 8'h40);
      wr(chan(3, 0), 8'h10);
      cex_in[3] = 1'b1;
      @(negedge clk);
      rd_check("R8 rising ignored", chan(3, 1), 8'h34);
      wr(A_CNTH, 8'h9A); wr(A_CNTL, 8'hBC);
      cex_in[3] = 1'b0;
      @(negedge clk);
      rd_check("R8 falling low", chan(3, 1), 8'hBC);
      rd_check("R8 falling high", chan(3, 2), 8'h9A);
      wr(chan(3, 0), 8'h00); wr(A_CTRL, 8'h40);
   endtask

   task automatic t_watchdog(); // R9
      wr(A_GMODE, 8'h03);
      wr(chan(4, 1), 8'h10); wr(chan(4, 2), 8'h00);
      wr(A_CNTH, 8'h00); wr(A_CNTL, 8'h00);
      wdt_seen = 0;
      run_ticks(8);
      wr(chan(4, 1), 8'h20); wr(chan(4, 2), 8'h00);
      run_ticks(20);
      check("R9 rewrite avoids reset", wdt_seen, 0);
      run_ticks(8);
      check("R9 single reset pulse", wdt_seen, 1);
      rd_check("R9 no flag", A_CTRL, 8'h40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_overflow();
      t_enable();
      t_timer();
      t_hso();
      t_pwm();
      t_capture();
      t_watchdog();
      summary_and_end();
   end

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      summary_and_end();
   end
endmodule